// File: doc/BRIEF.md
# Parallel Bus Target Phase Sequencer

This block is the target side of a narrow 8-bit parallel peripheral bus. It watches for its own selection, takes the bus by pulling BSY low, and then moves the bus through command, data-in, status and message-in phases. Each byte crosses the bus with an interlocked REQ/ACK handshake and carries odd parity. All control lines are active low. A line that is released reads as 1.

Command length comes from the top three bits of the first command byte. Only the 6-byte block-read opcode 0x08 is served. Byte 4 of that command gives a block count, and the block returns that many blocks of bytes from an internal pattern source. A parity error on a received byte, or any other opcode, ends the command with a check-condition status and no data. The initiator's SEL and ACK are asynchronous to the block's clock, so each passes through a two-flop synchronizer. Output-enable signals stand in for the tristate drivers.

Top module: `bus_target_seq`

## Requirements
- R1: While reset is held, and after it, bsy_n, req_n, msg_n, cd_n and io_n are all 1 and db_oe is 0.
- R2: The block is selected when sel_n is low and data bit ID_BIT (bit 1 by default) is 1. It then drives bsy_n to 0. If sel_n is low and that bit is 0, bsy_n stays 1.
- R3: After the initiator releases sel_n, the phase code {msg_n, cd_n, io_n} is 3'b101 (command) for every command byte. Phases only advance in the order command, data-in (110), status (100), message-in (000).
- R4: req_n falls only while the synchronised ACK is high. It stays low until ACK has been seen low, and it does not fall again while ACK remains low.
- R5: Every byte the target drives carries dbp_out equal to the inverse of the XOR of the eight data bits, which gives odd parity over nine lines.
- R6: For opcode 0x08 with block count L > 0, the data-in phase carries L*BLOCK_BYTES bytes. Byte k of block b has the value (k mod 256) XOR b.
- R7: A command that completes without error produces one status byte 0x00, then one message-in byte 0x00. After that BSY is released and the phase lines return to 3'b111.
- R8: A byte received in the command phase whose nine lines carry even parity makes the status byte 0x02 and skips data-in.
- R9: An opcode other than 0x08 makes the status byte 0x02 and skips data-in.
- R10: Command length follows opcode bits [7:5]: 3'b001 or 3'b010 give 10 bytes, 3'b101 gives 12 bytes, and any other value gives 6 bytes.
- R11: Opcode 0x08 with a block count of 0 skips data-in and returns status 0x00.
- R12: db_oe is 0 throughout the command phase and 1 while the target presents a data-in, status or message-in byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Select line from initiator, active low, asynchronous |
| ack_n | input | 1 | Acknowledge from initiator, active low, asynchronous |
| db_in | input | 8 | Data bus as seen at the pins |
| dbp_in | input | 1 | Data parity line as seen at the pins |
| bsy_n | output | 1 | Busy, low while the target holds the bus |
| req_n | output | 1 | Request, low while a byte is offered or wanted |
| msg_n | output | 1 | Phase code bit 2 |
| cd_n | output | 1 | Phase code bit 1 (control/data) |
| io_n | output | 1 | Phase code bit 0, high when the initiator drives data |
| db_oe | output | 1 | Enable for the target's data and parity drivers |
| db_out | output | 8 | Data byte driven by the target |
| dbp_out | output | 1 | Parity bit driven by the target |

## Verification
The checks assume an initiator that obeys the interlock. It asserts ACK only after REQ has fallen, and it keeps ACK low until REQ has risen. It releases ACK before the target can raise the next REQ. It holds the data bus steady while SEL or ACK is low, so the unsynchronised data sampled after the sync delay is valid. The bench initiator only reacts to req_n and bsy_n seen on falling clock edges. It changes data at least two cycles before it pulls ACK, and it releases ACK one cycle after it sees REQ high. It therefore never violates these assumptions, even when it deliberately holds ACK for tens of cycles.

// File: rtl/bus_target_seq.sv
module bus_target_seq #(
  parameter int         ID_BIT      = 1,
  parameter int         BLOCK_BYTES = 512,
  parameter logic [7:0] READ_OP     = 8'h08
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_n,
  input  logic       ack_n,
  input  logic [7:0] db_in,
  input  logic       dbp_in,
  output logic       bsy_n,
  output logic       req_n,
  output logic       msg_n,
  output logic       cd_n,
  output logic       io_n,
  output logic       db_oe,
  output logic [7:0] db_out,
  output logic       dbp_out
);
  localparam int BW = $clog2(BLOCK_BYTES);
  localparam int CW = (BW > 4) ? BW : 4;
  localparam logic [CW-1:0] LAST_IN_BLK = CW'(BLOCK_BYTES - 1);

  typedef enum logic [2:0] {S_IDLE, S_SELD, S_SETUP, S_REQ, S_ACKW} state_t;
  typedef enum logic [1:0] {P_CMD, P_DIN, P_STAT, P_MSG} phase_t;

  state_t        st;
  phase_t        ph;
  logic [1:0]    sel_q, ack_q;
  logic          sel_s, ack_s;
  logic [CW-1:0] cnt, cmd_len;
  logic [7:0]    blk, opc, xfer_len;
  logic          perr, reject;
  logic [2:0]    code;

  assign sel_s  = sel_q[1];
  assign ack_s  = ack_q[1];
  assign reject = perr || (opc != READ_OP);

  always_comb begin
    case (opc[7:5])
      3'd1, 3'd2: cmd_len = CW'(10);
      3'd5:       cmd_len = CW'(12);
      default:    cmd_len = CW'(6);
    endcase
  end

  always_comb begin
    if (st == S_IDLE || st == S_SELD) code = 3'b111;
    else begin
      case (ph)
        P_CMD:   code = 3'b101;
        P_DIN:   code = 3'b110;
        P_STAT:  code = 3'b100;
        default: code = 3'b000;
      endcase
    end
  end

  always_comb begin
    case (ph)
      P_DIN:   db_out = 8'(cnt) ^ blk;
      P_STAT:  db_out = reject ? 8'h02 : 8'h00;
      default: db_out = 8'h00;
    endcase
  end

  assign {msg_n, cd_n, io_n} = code;
  assign bsy_n   = (st == S_IDLE);
  assign req_n   = (st != S_REQ);
  assign db_oe   = (st == S_SETUP || st == S_REQ || st == S_ACKW) && (ph != P_CMD);
  assign dbp_out = ~^db_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 2'b11;
      ack_q <= 2'b11;
    end else begin
      sel_q <= {sel_q[0], sel_n};
      ack_q <= {ack_q[0], ack_n};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      ph       <= P_CMD;
      cnt      <= '0;
      blk      <= '0;
      opc      <= '0;
      xfer_len <= '0;
      perr     <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (!sel_s && db_in[ID_BIT]) begin
          st       <= S_SELD;
          perr     <= 1'b0;
          opc      <= '0;
          xfer_len <= '0;
        end
        S_SELD: if (sel_s) begin
          st  <= S_SETUP;
          ph  <= P_CMD;
          cnt <= '0;
          blk <= '0;
        end
        S_SETUP: st <= S_REQ;
        S_REQ: if (!ack_s) begin
          st <= S_ACKW;
          if (ph == P_CMD) begin
            if (cnt == '0) opc <= db_in;
            if (cnt == CW'(4)) xfer_len <= db_in;
            if (!(^{db_in, dbp_in})) perr <= 1'b1;
          end
        end
        S_ACKW: if (ack_s) begin
          st <= S_SETUP;
          case (ph)
            P_CMD:
              if (cnt == cmd_len - CW'(1)) begin
                cnt <= '0;
                blk <= '0;
                ph  <= (!reject && xfer_len != 8'd0) ? P_DIN : P_STAT;
              end else cnt <= cnt + CW'(1);
            P_DIN:
              if (cnt == LAST_IN_BLK) begin
                cnt <= '0;
                if (blk == xfer_len - 8'd1) ph <= P_STAT;
                else blk <= blk + 8'd1;
              end else cnt <= cnt + CW'(1);
            P_STAT: ph <= P_MSG;
            default: begin
              st <= S_IDLE;
              ph <= P_CMD;
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module bus_target_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       ack_s,
  input logic       bsy_n,
  input logic       req_n,
  input logic       msg_n,
  input logic       cd_n,
  input logic       io_n,
  input logic       db_oe,
  input logic [7:0] db_out
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (bsy_n && req_n && msg_n && cd_n && io_n && !db_oe));

  // R4
  req_start_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(req_n) |-> ack_s);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_n && ack_s) |=> !req_n);

  // R3
  phase_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_n && $past(!req_n)) |-> $stable({msg_n, cd_n, io_n}));

  // R5
  data_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_n && $past(!req_n) && db_oe) |-> $stable(db_out));

  // R12
  cmd_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_n && {msg_n, cd_n, io_n} == 3'b101) |-> !db_oe);

  // R7
  release_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bsy_n) |-> ($past({msg_n, cd_n, io_n}) == 3'b000));
endmodule

bind bus_target_seq bus_target_seq_chk u_chk (
  .clk(clk), .rst(rst), .ack_s(ack_s), .bsy_n(bsy_n), .req_n(req_n),
  .msg_n(msg_n), .cd_n(cd_n), .io_n(io_n), .db_oe(db_oe), .db_out(db_out)
);

// File: tb/tb_bus_target_seq.sv
module tb_bus_target_seq;
  localparam int BLK = 512;
  // opcode, block count, bad-parity byte index (F = none), status, blocks, cmd length
  localparam logic [39:0] VEC [9] = '{
    {8'h08, 8'h01, 4'hF, 8'h00, 8'd1, 4'd6},
    {8'h08, 8'h02, 4'hF, 8'h00, 8'd2, 4'd6},
    {8'h08, 8'h00, 4'hF, 8'h00, 8'd0, 4'd6},
    {8'h08, 8'h01, 4'h2, 8'h02, 8'd0, 4'd6},
    {8'h12, 8'h01, 4'hF, 8'h02, 8'd0, 4'd6},
    {8'h28, 8'h01, 4'hF, 8'h02, 8'd0, 4'd10},
    {8'hA8, 8'h01, 4'hF, 8'h02, 8'd0, 4'd12},
    {8'hE0, 8'h00, 4'hF, 8'h02, 8'd0, 4'd6},
    {8'h08, 8'h01, 4'h5, 8'h02, 8'd0, 4'd6}
  };

  logic clk = 1'b0, rst = 1'b1, sel_n = 1'b1, ack_n = 1'b1, dbp_in = 1'b1;
  logic [7:0] db_in = 8'hFF;
  logic bsy_n, req_n, msg_n, cd_n, io_n, db_oe, dbp_out;
  logic [7:0] db_out;

  int nchk = 0, nfail = 0;
  int ncmd, ndata, nderr, nst, nmsg, nperr, nord, noe, slowerr;
  logic [7:0] stb, msgb;
  bit selok, done = 1'b0;

  always #4 clk = ~clk;

  bus_target_seq dut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .ack_n(ack_n), .db_in(db_in), .dbp_in(dbp_in),
    .bsy_n(bsy_n), .req_n(req_n), .msg_n(msg_n), .cd_n(cd_n), .io_n(io_n),
    .db_oe(db_oe), .db_out(db_out), .dbp_out(dbp_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_txn(input logic [7:0] opc, input logic [7:0] len,
                         input logic [3:0] bad, input bit slow);
    int wt, rank, r;
    bit first;
    logic [2:0] ph;
    logic [7:0] b;
    ncmd = 0; ndata = 0; nderr = 0; nst = 0; nmsg = 0;
    nperr = 0; nord = 0; noe = 0; slowerr = 0; stb = 8'hFF; msgb = 8'hFF;
    sel_n = 1'b0; db_in = 8'h82; dbp_in = ~^8'h82;
    wt = 0;
    while (bsy_n && wt < 100) begin @(negedge clk); wt++; end
    selok = !bsy_n;
    sel_n = 1'b1; db_in = 8'hFF; dbp_in = 1'b1;
    if (!selok) return;
    rank = 0;
    first = 1'b1;
    forever begin
      wt = 0;
      while (req_n && !bsy_n && wt < 1000) begin @(negedge clk); wt++; end
      if (bsy_n || wt >= 1000) break;
      ph = {msg_n, cd_n, io_n};
      case (ph)
        3'b101:  r = 0;
        3'b110:  r = 1;
        3'b100:  r = 2;
        3'b000:  r = 3;
        default: r = 9;
      endcase
      if (r == 9 || r < rank) nord++; else rank = r;
      if (ph == 3'b101) begin
        b = (ncmd == 0) ? opc : (ncmd == 4) ? len : 8'h00;
        db_in = b;
        dbp_in = (ncmd == int'(bad)) ? ^b : ~^b;
        if (db_oe) noe++;
        ncmd++;
      end else begin
        if (!db_oe) noe++;
        if (dbp_out != ~^db_out) nperr++;
        if (ph == 3'b110) begin
          if (db_out != (8'(ndata % BLK) ^ 8'(ndata / BLK))) nderr++;
          ndata++;
        end else if (ph == 3'b100) begin
          stb = db_out; nst++;
        end else begin
          msgb = db_out; nmsg++;
        end
      end
      if (slow && first) begin
        repeat (30) @(negedge clk);
        if (req_n) slowerr++;
      end
      repeat (2) @(negedge clk);
      ack_n = 1'b0;
      wt = 0;
      while (!req_n && wt < 50) begin @(negedge clk); wt++; end
      if (!req_n) slowerr++;
      if (slow && first) begin
        repeat (30) @(negedge clk);
        if (!req_n) slowerr++;
      end
      @(negedge clk);
      ack_n = 1'b1; db_in = 8'hFF; dbp_in = 1'b1;
      first = 1'b0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1 reset lines", {bsy_n, req_n, msg_n, cd_n, io_n, db_oe}, 6'b111110);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 after reset", {bsy_n, req_n, msg_n, cd_n, io_n, db_oe}, 6'b111110);

    for (int i = 0; i < 9; i++) begin
      logic [39:0] v;
      v = VEC[i];
      run_txn(v[39:32], v[31:24], v[23:20], 1'b0);
      check("R2 selected", int'(selok), 1);
      check("R10 command length", ncmd, int'(v[3:0]));
      check("R3 phase order", nord, 0);
      check("R6 data-in count", ndata, int'(v[11:4]) * BLK);
      check("R6 data pattern", nderr, 0);
      check("R7 R8 R9 R11 status byte", int'(stb), int'(v[19:12]));
      check("R7 one status", nst, 1);
      check("R7 message-in byte", int'(msgb), 0);
      check("R7 one message", nmsg, 1);
      check("R5 target parity", nperr, 0);
      check("R12 output enable", noe, 0);
      check("R4 handshake", slowerr, 0);
      @(negedge clk);
      check("R7 bus released", {bsy_n, msg_n, cd_n, io_n}, 4'b1111);
      repeat (5) @(negedge clk);
    end

    // R2: own ID bit clear, no response
    sel_n = 1'b0; db_in = 8'h81; dbp_in = ~^8'h81;
    repeat (20) @(negedge clk);
    check("R2 not selected", int'(bsy_n), 1);
    sel_n = 1'b1; db_in = 8'hFF; dbp_in = 1'b1;
    repeat (5) @(negedge clk);

    // R4: ACK held off and then held low for long stretches
    run_txn(8'h08, 8'h01, 4'hF, 1'b1);
    check("R4 slow initiator", slowerr, 0);
    check("R4 slow status", int'(stb), 0);
    check("R6 slow data count", ndata, BLK);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule